// File: doc/BRIEF.md
# Four-Channel DMA Service Selector

This block decides which of four DMA channels a transfer sequencer serves next. A channel can win only when software has enabled it in the low bits of an 8-bit priority control byte and its peripheral is raising a transfer request. The top bit of the same byte selects the ordering. When the bit is clear, the order is fixed and a lower channel number beats a higher one. When the bit is set, the order rotates so that the channel served most recently drops to the bottom.

The sequencer pulses a one-cycle select strobe while it is idle. On that clock edge the block registers its decision: a grant-valid flag and the 2-bit number of the winning channel. A winning channel also becomes the stored last-served channel. Between strobes the grant outputs do not change, whatever the requests and the priority byte do. This keeps the channel under transfer fixed until the sequencer returns to idle and asks again.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is held (synchronous, active low), at the next clock edge grant_valid goes to 0 and grant_chan goes to 0.
- R2: A channel is eligible only when its enable bit (prio_ctrl bit n for channel n, bits 3:0) is 1 and xfer_req[n] is 1. A grant issued by a strobe always names a channel that was eligible at that strobe.
- R3: A strobe with no eligible channel gives grant_valid = 0 from the next cycle. grant_chan keeps its previous value.
- R4: With prio_ctrl bit 7 = 0, a strobe grants the lowest-numbered eligible channel.
- R5: With prio_ctrl bit 7 = 1, the search starts at the channel after the last-served one and wraps round from 3 to 0. The last-served channel therefore has the lowest priority, and it can still win when it is the only eligible channel. For example, after channel 1 the order is 2, 3, 0, 1.
- R6: Every granted channel becomes the last-served channel, in either ordering mode. A strobe with no eligible channel leaves the last-served channel unchanged.
- R7: When sel_strobe is 0 at a clock edge, grant_valid and grant_chan keep their values, whatever happens on prio_ctrl and xfer_req.
- R8: After reset the last-served channel is 3, so the first rotating search puts channel 0 first.
- R9: prio_ctrl bits 6:4 do not affect the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prio_ctrl | input | 8 | Priority control byte: bits 3:0 are the channel enables, bit 7 selects rotating order |
| xfer_req | input | 4 | Transfer request, one bit per channel |
| sel_strobe | input | 1 | Take a decision on this clock edge |
| grant_valid | output | 1 | The last decision found an eligible channel |
| grant_chan | output | 2 | Number of the granted channel |

## Verification
A walked vector list runs a sequence of strobes. Fixed-order cases use sparse request masks, all requests on, and disabled but requesting channels. These separate lowest-index selection from enable gating. Rotating cases with all requests on step the grant through 0, 1, 2, 3. Further rotating cases with a single requester show that the last-served channel can still win alone, and mixed masks show the wrap past channel 3. Directed cases check the reset state, the first rotating grant after reset, a strobe with no eligible channel between two rotating grants (the stored channel must not move), outputs holding while inputs toggle without a strobe, and noise on bits 6:4.

// File: rtl/dma_arb_pkg.sv
// Package dma_arb_pkg
// Shared default sizes for the DMA channel selector.
// Assumes a power-of-two or small channel count, at least two channels.
package dma_arb_pkg;
    localparam int unsigned NUM_CH  = 4;
    localparam int unsigned CH_W    = $clog2(NUM_CH);
    localparam int unsigned PRIO_W  = 8;
    localparam int unsigned ROT_POS = 7;
endpackage

// File: rtl/chan_eligibility.sv
// Module chan_eligibility
// Combines the per-channel enable bits with the request lines.
// Assumes the enables sit in the low NUM_CH bits of the control byte.
module chan_eligibility #(
    parameter int unsigned NUM_CH = dma_arb_pkg::NUM_CH
) (
    input  logic [NUM_CH-1:0] en_bits,
    input  logic [NUM_CH-1:0] req,
    output logic [NUM_CH-1:0] elig
);
    // One AND gate per channel: enabled and requesting.
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        assign elig[n] = en_bits[n] & req[n];
    end
endmodule

// File: rtl/rot_pick.sv
// Module rot_pick
// Combinational search for the first eligible channel, starting one
// past a base channel and wrapping. Fixed order uses base = NUM_CH-1,
// so the search starts at channel 0. Assumes NUM_CH >= 2.
module rot_pick #(
    parameter int unsigned NUM_CH = dma_arb_pkg::NUM_CH,
    localparam int unsigned CW    = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic              rotate,
    input  logic [CW-1:0]     last_chan,
    output logic              any,
    output logic [CW-1:0]     win
);
    logic [CW-1:0]     base;
    logic [CW-1:0]     cand [NUM_CH];
    logic [NUM_CH-1:0] rot_elig;

    // Rotating order starts after the last-served channel, fixed order after the top one.
    assign base = rotate ? last_chan : CW'(NUM_CH - 1);

    // Search slot k looks at channel (base + 1 + k) mod NUM_CH.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_slot
        logic [CW:0] sum;
        assign sum         = {1'b0, base} + (CW+1)'(k + 1);
        assign cand[k]     = (sum >= (CW+1)'(NUM_CH)) ? CW'(sum - (CW+1)'(NUM_CH)) : CW'(sum);
        assign rot_elig[k] = elig[cand[k]];
    end

    // Take the first eligible slot in search order.
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = NUM_CH - 1; k >= 0; k--) begin
            if (rot_elig[k]) begin
                any = 1'b1;
                win = cand[k];
            end
        end
    end
endmodule

// File: rtl/last_served_reg.sv
// Module last_served_reg
// Holds the number of the most recently granted channel.
// Loads only when a strobe finds a winner. Synchronous active-low reset.
module last_served_reg #(
    parameter int unsigned CW        = dma_arb_pkg::CH_W,
    parameter logic [CW-1:0] RST_VAL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] din,
    output logic [CW-1:0] q
);
    // Capture the winner; reset sets the top channel.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= RST_VAL;
        else if (load) q <= din;
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
// Module dma_chan_arbiter
// Picks the next DMA channel to serve on each select strobe, using either
// fixed or rotating priority. The grant stays registered until the next
// strobe. Assumes the sequencer strobes only while it is idle.
module dma_chan_arbiter #(
    parameter int unsigned NUM_CH  = dma_arb_pkg::NUM_CH,
    parameter int unsigned PRIO_W  = dma_arb_pkg::PRIO_W,
    parameter int unsigned ROT_POS = dma_arb_pkg::ROT_POS,
    localparam int unsigned CW     = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRIO_W-1:0] prio_ctrl,
    input  logic [NUM_CH-1:0] xfer_req,
    input  logic              sel_strobe,
    output logic              grant_valid,
    output logic [CW-1:0]     grant_chan
);
    logic [NUM_CH-1:0] elig;
    logic              any;
    logic [CW-1:0]     win;
    logic [CW-1:0]     last_q;
    logic              rotate;

    assign rotate = prio_ctrl[ROT_POS];

    // Bits between the enables and the mode bit take no part in the decision.
    if (ROT_POS > NUM_CH) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^prio_ctrl[ROT_POS-1:NUM_CH];
    end
    if (PRIO_W > ROT_POS + 1) begin : g_upper
        logic unused_upper;
        assign unused_upper = ^prio_ctrl[PRIO_W-1:ROT_POS+1];
    end

    chan_eligibility #(.NUM_CH(NUM_CH)) i_elig (
        .en_bits (prio_ctrl[NUM_CH-1:0]),
        .req     (xfer_req),
        .elig    (elig)
    );

    rot_pick #(.NUM_CH(NUM_CH)) i_pick (
        .elig      (elig),
        .rotate    (rotate),
        .last_chan (last_q),
        .any       (any),
        .win       (win)
    );

    last_served_reg #(.CW(CW), .RST_VAL(CW'(NUM_CH - 1))) i_last (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sel_strobe & any),
        .din   (win),
        .q     (last_q)
    );

    // Register the decision on a strobe; the channel number holds when nothing is eligible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid <= 1'b0;
            grant_chan  <= '0;
        end else if (sel_strobe) begin
            grant_valid <= any;
            if (any) grant_chan <= win;
        end
    end

    // R2
    grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_strobe |=> (!grant_valid || ((($past(elig) >> grant_chan) & NUM_CH'(1)) != '0)));

    // R3
    none_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && elig == '0) |=> (!grant_valid && $stable(grant_chan)));

    // R4
    fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && !rotate && elig != '0) |=>
            (($past(elig) & ((NUM_CH'(1) << grant_chan) - NUM_CH'(1))) == '0));

    // R5
    rotate_demote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && rotate && $countones(elig) > 1) |=> (grant_chan != $past(last_q)));

    // R6
    last_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_strobe && elig != '0) |=> (last_q == grant_chan));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_strobe |=> ($stable(grant_valid) && $stable(grant_chan)));
endmodule

// File: tb/test_dma_chan_arbiter.sv
module test_dma_chan_arbiter;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] prio_ctrl;
    logic [3:0] xfer_req;
    logic       sel_strobe;
    logic       grant_valid;
    logic [1:0] grant_chan;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dma_chan_arbiter i_dma_chan_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .prio_ctrl   (prio_ctrl),
        .xfer_req    (xfer_req),
        .sel_strobe  (sel_strobe),
        .grant_valid (grant_valid),
        .grant_chan  (grant_chan)
    );

    // Layout: [14:7] priority byte, [6:3] requests, [2] expected valid, [1:0] expected channel.
    localparam int NV = 16;
    localparam logic [14:0] VEC [NV] = '{
        {8'h0F, 4'b1010, 1'b1, 2'd1},   // R4 fixed, sparse
        {8'h0F, 4'b1111, 1'b1, 2'd0},   // R4 all requesting
        {8'h0F, 4'b1000, 1'b1, 2'd3},   // R4 only top
        {8'h03, 4'b1100, 1'b0, 2'd3},   // R2/R3 requesters disabled
        {8'h8F, 4'b1111, 1'b1, 2'd0},   // R5 rotate after 3
        {8'h8F, 4'b1111, 1'b1, 2'd1},   // R5
        {8'h8F, 4'b1111, 1'b1, 2'd2},   // R5
        {8'h8F, 4'b1111, 1'b1, 2'd3},   // R5
        {8'h8F, 4'b0011, 1'b1, 2'd0},   // R5 wrap
        {8'h8F, 4'b0001, 1'b1, 2'd0},   // R5 last-served wins alone
        {8'h8E, 4'b0011, 1'b1, 2'd1},   // R2 enable gates ch0
        {8'h8F, 4'b1011, 1'b1, 2'd3},   // R5 order 2,3,0,1
        {8'hF5, 4'b1111, 1'b1, 2'd0},   // R9 spare bits set, rotating
        {8'hF5, 4'b1111, 1'b1, 2'd2},   // R9 / R6
        {8'h75, 4'b1111, 1'b1, 2'd0},   // R9 fixed with spare bits
        {8'h00, 4'b1111, 1'b0, 2'd0}    // R3 nothing enabled
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pick(input logic [7:0] p, input logic [3:0] r);
        @(negedge clk);
        prio_ctrl  = p;
        xfer_req   = r;
        sel_strobe = 1'b1;
        @(negedge clk);
        sel_strobe = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n      = 1'b0;
        prio_ctrl  = 8'h00;
        xfer_req   = 4'h0;
        sel_strobe = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 valid", {1'b0, grant_valid}, 2'd0);
        check("R1 chan", grant_chan, 2'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            pick(VEC[i][14:7], VEC[i][6:3]);
            check($sformatf("R2-R9 vec%0d valid", i), {1'b0, grant_valid}, {1'b0, VEC[i][2]});
            check($sformatf("R2-R9 vec%0d chan", i), grant_chan, VEC[i][1:0]);
        end

        // R7 hold without strobe
        pick(8'h0F, 4'b0100);
        check("R7 setup", grant_chan, 2'd2);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            prio_ctrl = 8'h8F ^ 8'(j);
            xfer_req  = 4'b0001 << j;
        end
        @(negedge clk);
        check("R7 valid", {1'b0, grant_valid}, 2'd1);
        check("R7 chan", grant_chan, 2'd2);

        // R8 first rotating search after reset
        do_reset();
        pick(8'h8F, 4'b1111);
        check("R8 chan", grant_chan, 2'd0);

        // R6 no-eligible strobe keeps last-served; R3 channel held
        pick(8'h8F, 4'b0010);
        check("R6 grant1", grant_chan, 2'd1);
        pick(8'h8F, 4'b0000);
        check("R3 valid", {1'b0, grant_valid}, 2'd0);
        check("R3 chan held", grant_chan, 2'd1);
        pick(8'h8F, 4'b1111);
        check("R6 after empty", grant_chan, 2'd2);
        check("R6 valid", {1'b0, grant_valid}, 2'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule